// File: doc/BRIEF.md
# RC Time-Constant Calibration Controller

This block is the digital controller for a one-shot calibration of an on-chip RC time constant. It runs from the reference clock. After reset it alternates between two phases. In the hold phase an external replica integrator is held at its common-mode point. In the ramp phase that integrator is released, and the block counts reference cycles until an external comparator reports that the integrator output has crossed its threshold. The count is taken away from a programmable bandwidth code, which is the nominal RC value for the selected channel bandwidth. The difference is clipped and loaded into a 5-bit capacitor code that sets the filter capacitor banks.

The hold/ramp/load cycle repeats until the capacitor code has stayed unchanged for a programmable number of consecutive passes. The block then powers down the calibration circuitry, withdraws the enable of the reference clock gate, raises its done flag and keeps the final code until the next reset. A start pulse during a run throws the run away and begins again from the first pass.

Top module: `rccal_ctrl`

## Requirements
- R1: While reset is active and directly after it, `integ_hold` is 1, `cal_done` and `cal_pwr_off` are 0, `ref_clk_en` is 1, and `cap_code` holds the midscale value 16. A run starts with no further input.
- R2: Each pass starts with `integ_hold` high for HOLD_CYC reference cycles (default 16). `integ_hold` then goes low for the ramp. `integ_hold` is also high for the single load cycle that ends each pass, so between two ramps it is high for HOLD_CYC+1 cycles.
- R3: During the ramp a 6-bit counter starts at 0 and advances once per cycle in which `comp_flag` is low. The ramp ends in the first cycle where `comp_flag` is high, which keeps the count, or where the count is 63, which ends the pass with 63. A flag that first appears after K ramp cycles therefore gives a ramp of min(K,63)+1 cycles.
- R4: At the end of each pass, `cap_code` becomes `bw_code` minus the count, limited to 0 when the count is larger than `bw_code` and to 31 when the difference is above 31.
- R5: A pass is "unchanged" when its new code equals the code it replaces. The run finishes on the pass that makes the number of consecutive unchanged passes reach `stable_need`, where a value of 0 is treated as 1. Any changed pass sets that number back to zero.
- R6: When finished, `cal_done` and `cal_pwr_off` are 1, `ref_clk_en` is 0, `integ_hold` is 1, and `cap_code` keeps the final value. All of these stay that way until reset.
- R7: A `start` pulse while the run is not finished sends the block back to the hold phase in the next cycle, with `cap_code` at 16 and the unchanged-pass count cleared.
- R8: After finishing, `start` has no effect: all outputs stay unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_ref | input | 1 | Reference clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Restart pulse, used only while a run is in progress |
| comp_flag | input | 1 | Comparator output, high once the integrator has crossed the threshold |
| bw_code | input | 7 | Nominal RC code for the selected channel bandwidth |
| stable_need | input | 3 | Required number of consecutive unchanged passes (0 acts as 1) |
| integ_hold | output | 1 | High holds the replica integrator in reset, low lets it ramp |
| cal_pwr_off | output | 1 | Powers down the calibration circuitry |
| ref_clk_en | output | 1 | Enable for the gate of the reference clock, low once finished |
| cal_done | output | 1 | Calibration finished, sticky until reset |
| cap_code | output | 5 | Capacitor bank control word |

## Verification
The main loop is run with four patterns. The first uses a constant comparator delay that moves the code away from midscale once and then settles; it separates counting of changed passes from counting of unchanged ones. The second uses a sequence of delays that drives the difference above 31 and then through two different values before it settles; it exposes a missing upper clip and a stability count that survives a change. The third never raises the comparator, which checks the count saturating at 63 and the clip at zero. The fourth gives a code equal to midscale together with a requirement of 0, which must finish on the first pass. A restart in the middle of a ramp is checked against a fresh expected sequence.

// File: rtl/rccal_pkg.sv
package rccal_pkg;

  typedef enum logic [1:0] {
    PH_HOLD = 2'd0,
    PH_RAMP = 2'd1,
    PH_LOAD = 2'd2,
    PH_OFF  = 2'd3
  } cal_phase_e;

  // Difference of two unsigned values, clipped to [0, ceiling].
  function automatic logic [15:0] clamp_diff(input logic [15:0] minuend,
                                             input logic [15:0] subtr,
                                             input logic [15:0] ceiling);
    logic [15:0] diff;
    if (subtr >= minuend) return 16'd0;
    diff = minuend - subtr;
    if (diff > ceiling) return ceiling;
    return diff;
  endfunction

endpackage

// File: rtl/rccal_seq.sv
module rccal_seq
  import rccal_pkg::*;
#(
  parameter int HOLD_CYC = 16
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start,
  input  logic       ramp_end,
  input  logic       finish_now,
  output cal_phase_e phase,
  output logic       restart,
  output logic       load_stb
);
  localparam int TW = $clog2(HOLD_CYC + 1);
  localparam logic [TW-1:0] HOLD_LAST = TW'(HOLD_CYC - 1);

  logic [TW-1:0] hold_tmr;

  assign restart  = start && (phase != PH_OFF);
  assign load_stb = (phase == PH_LOAD) && !restart;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase    <= PH_HOLD;
      hold_tmr <= '0;
    end else if (restart) begin
      phase    <= PH_HOLD;
      hold_tmr <= '0;
    end else begin
      case (phase)
        PH_HOLD: begin
          if (hold_tmr == HOLD_LAST) begin
            phase    <= PH_RAMP;
            hold_tmr <= '0;
          end else begin
            hold_tmr <= hold_tmr + 1'b1;
          end
        end
        PH_RAMP: if (ramp_end) phase <= PH_LOAD;
        PH_LOAD: phase <= finish_now ? PH_OFF : PH_HOLD;
        default: phase <= PH_OFF;
      endcase
    end
  end

  assert_done_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_OFF) |=> (phase == PH_OFF));

  assert_hold_length_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_RAMP && $past(phase) == PH_HOLD) |-> ($past(hold_tmr) == HOLD_LAST));

  assert_restart_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (start && phase != PH_OFF) |=> (phase == PH_HOLD && hold_tmr == '0));

endmodule

// File: rtl/rccal_ramp_cnt.sv
module rccal_ramp_cnt #(
  parameter int CNT_W = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             clr,
  input  logic             comp_flag,
  output logic [CNT_W-1:0] cnt,
  output logic             ramp_end
);
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  logic at_max;
  assign at_max   = (cnt == CNT_MAX);
  assign ramp_end = run && (comp_flag || at_max);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                cnt <= '0;
    else if (clr)              cnt <= '0;
    else if (run && !ramp_end) cnt <= cnt + 1'b1;
  end

  assert_cnt_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !clr && !comp_flag && !at_max) |=> (cnt == CNT_W'($past(cnt) + 1'b1)));

  assert_cnt_freeze_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !clr && comp_flag) |=> $stable(cnt));

endmodule

// File: rtl/rccal_code_trk.sv
module rccal_code_trk
  import rccal_pkg::*;
#(
  parameter int CODE_W = 5,
  parameter int BW_W   = 7,
  parameter int CNT_W  = 6,
  parameter int NEED_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clear,
  input  logic              load_stb,
  input  logic [BW_W-1:0]   bw_code,
  input  logic [CNT_W-1:0]  ramp_cnt,
  input  logic [NEED_W-1:0] stable_need,
  output logic [CODE_W-1:0] cap_code,
  output logic              finish_now
);
  localparam logic [CODE_W-1:0] CODE_INIT = CODE_W'(1 << (CODE_W - 1));
  localparam int CODE_MAX = (1 << CODE_W) - 1;

  logic [CODE_W-1:0] new_code;
  logic [NEED_W-1:0] same_run;
  logic [NEED_W-1:0] need_eff;
  logic [NEED_W:0]   run_inc;
  logic [NEED_W-1:0] run_next;
  logic              same;

  assign new_code   = CODE_W'(clamp_diff(16'(bw_code), 16'(ramp_cnt), 16'(CODE_MAX)));
  assign need_eff   = (stable_need == '0) ? NEED_W'(1) : stable_need;
  assign same       = (new_code == cap_code);
  assign run_inc    = {1'b0, same_run} + 1'b1;
  assign run_next   = run_inc[NEED_W] ? {NEED_W{1'b1}} : run_inc[NEED_W-1:0];
  assign finish_now = same && (run_inc >= {1'b0, need_eff});

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cap_code <= CODE_INIT;
      same_run <= '0;
    end else if (clear) begin
      cap_code <= CODE_INIT;
      same_run <= '0;
    end else if (load_stb) begin
      cap_code <= new_code;
      same_run <= same ? run_next : '0;
    end
  end

  assert_code_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !(clear || load_stb) |=> $stable(cap_code));

  assert_clip_low_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (load_stb && !clear && {1'b0, bw_code} < (BW_W+1)'(ramp_cnt)) |=> (cap_code == '0));

  assert_finish_same_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (load_stb && !clear && finish_now) |=> $stable(cap_code));

endmodule

// File: rtl/rccal_ctrl.sv
module rccal_ctrl
  import rccal_pkg::*;
#(
  parameter int CNT_W    = 6,
  parameter int CODE_W   = 5,
  parameter int BW_W     = 7,
  parameter int NEED_W   = 3,
  parameter int HOLD_CYC = 16
) (
  input  logic              clk_ref,
  input  logic              rst_n,
  input  logic              start,
  input  logic              comp_flag,
  input  logic [BW_W-1:0]   bw_code,
  input  logic [NEED_W-1:0] stable_need,
  output logic              integ_hold,
  output logic              cal_pwr_off,
  output logic              ref_clk_en,
  output logic              cal_done,
  output logic [CODE_W-1:0] cap_code
);
  cal_phase_e       phase;
  logic             restart;
  logic             load_stb;
  logic             ramp_end;
  logic             finish_now;
  logic [CNT_W-1:0] ramp_cnt;

  rccal_seq #(.HOLD_CYC(HOLD_CYC)) u_seq (
    .clk        (clk_ref),
    .rst_n      (rst_n),
    .start      (start),
    .ramp_end   (ramp_end),
    .finish_now (finish_now),
    .phase      (phase),
    .restart    (restart),
    .load_stb   (load_stb)
  );

  rccal_ramp_cnt #(.CNT_W(CNT_W)) u_cnt (
    .clk       (clk_ref),
    .rst_n     (rst_n),
    .run       (phase == PH_RAMP),
    .clr       (phase == PH_HOLD),
    .comp_flag (comp_flag),
    .cnt       (ramp_cnt),
    .ramp_end  (ramp_end)
  );

  rccal_code_trk #(
    .CODE_W (CODE_W),
    .BW_W   (BW_W),
    .CNT_W  (CNT_W),
    .NEED_W (NEED_W)
  ) u_code (
    .clk         (clk_ref),
    .rst_n       (rst_n),
    .clear       (restart),
    .load_stb    (load_stb),
    .bw_code     (bw_code),
    .ramp_cnt    (ramp_cnt),
    .stable_need (stable_need),
    .cap_code    (cap_code),
    .finish_now  (finish_now)
  );

  assign integ_hold  = (phase != PH_RAMP);
  assign cal_done    = (phase == PH_OFF);
  assign cal_pwr_off = cal_done;
  assign ref_clk_en  = !cal_done;

  assert_done_after_load_R5: assert property (@(posedge clk_ref) disable iff (!rst_n)
    $rose(cal_done) |-> $past(load_stb));

  assert_start_ignored_R8: assert property (@(posedge clk_ref) disable iff (!rst_n)
    (cal_done && start) |=> (cal_done && $stable(cap_code)));

endmodule

// File: tb/sim_rccal_ctrl.sv
module sim_rccal_ctrl;
  localparam int HOLD = 16;
  localparam int MAXC = 63;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       start = 1'b0;
  logic       comp_flag = 1'b0;
  logic [6:0] bw_code = '0;
  logic [2:0] stable_need = 3'd3;
  logic       integ_hold, cal_pwr_off, ref_clk_en, cal_done;
  logic [4:0] cap_code;

  rccal_ctrl u0 (
    .clk_ref(clk), .rst_n(rst_n), .start(start), .comp_flag(comp_flag),
    .bw_code(bw_code), .stable_need(stable_need), .integ_hold(integ_hold),
    .cal_pwr_off(cal_pwr_off), .ref_clk_en(ref_clk_en), .cal_done(cal_done),
    .cap_code(cap_code)
  );

  always #5 clk = ~clk;

  typedef struct packed { logic [4:0] code; logic fin; } exp_t;
  exp_t q[$];

  int total = 0, bad = 0;
  int kv[32];
  int idx = 0, ramp = 0, lowcnt = 0, hicnt = 0, last_code = 16;
  bit prev_h = 1'b1, seen_rise = 1'b0, pend = 1'b0, mon_en = 1'b0;

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int expv);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, expv);
    end
  endtask

  function automatic int exp_low(input int k);
    return ((k >= MAXC) ? MAXC : k) + 1;
  endfunction

  // Driver side: expected code per pass, built from R4/R5.
  function automatic void build_exp(input int bw, input int need);
    int code = 16, run = 0, ne, c, r;
    bit fin;
    exp_t e;
    q.delete();
    ne = (need == 0) ? 1 : need;
    for (int i = 0; i < 32; i++) begin
      c = (kv[i] > MAXC) ? MAXC : kv[i];
      r = bw - c;
      if (r < 0) r = 0;
      if (r > 31) r = 31;
      if (r == code) run++; else run = 0;
      code = r;
      fin = (run >= ne);
      e.code = 5'(r); e.fin = fin;
      q.push_back(e);
      if (fin) break;
    end
    last_code = code;
  endfunction

  // Integrator/comparator model and monitor, evaluated away from the active edge.
  always @(negedge clk) begin : mon
    exp_t e;
    if (!rst_n) begin
      ramp = 0; comp_flag = 1'b0; prev_h = 1'b1; hicnt = 0; lowcnt = 0;
      seen_rise = 1'b0; pend = 1'b0;
    end else begin
      if (mon_en && pend) begin
        pend = 1'b0;
        if (q.size() == 0) chk(1'b0, "R5", "update with nothing expected", cap_code, -1);
        else begin
          e = q.pop_front();
          chk(cap_code == e.code, "R4", "cap_code after pass", cap_code, e.code);
          chk(cal_done == e.fin, "R5", "done after pass", cal_done, e.fin);
        end
      end
      if (integ_hold) begin
        if (!prev_h) begin
          if (mon_en) begin
            pend = 1'b1;
            chk(lowcnt == exp_low(kv[idx]), "R3", "ramp cycles", lowcnt, exp_low(kv[idx]));
          end
          if (idx < 31) idx++;
          hicnt = 0;
          seen_rise = 1'b1;
        end
        hicnt++;
        ramp = 0;
        comp_flag = 1'b0;
      end else begin
        if (prev_h) begin
          if (mon_en && seen_rise) chk(hicnt == HOLD + 1, "R2", "hold cycles between ramps", hicnt, HOLD + 1);
          lowcnt = 0;
        end
        lowcnt++;
        ramp++;
        comp_flag = (ramp > kv[idx]);
      end
      prev_h = integ_hold;
    end
  end

  task automatic start_run(input int bw, input int need, input bit chk_rst);
    build_exp(bw, need);
    @(posedge clk); #2;
    rst_n = 1'b0; bw_code = 7'(bw); stable_need = 3'(need); idx = 0; mon_en = 1'b1;
    repeat (3) @(posedge clk);
    #2;
    if (chk_rst) begin
      chk(integ_hold == 1'b1, "R1", "integ_hold in reset", integ_hold, 1);
      chk(cal_done == 1'b0, "R1", "cal_done in reset", cal_done, 0);
      chk(cal_pwr_off == 1'b0, "R1", "cal_pwr_off in reset", cal_pwr_off, 0);
      chk(ref_clk_en == 1'b1, "R1", "ref_clk_en in reset", ref_clk_en, 1);
      chk(cap_code == 5'd16, "R1", "cap_code in reset", cap_code, 16);
    end
    rst_n = 1'b1;
  endtask

  task automatic wait_done(input string req);
    int n = 0;
    while (!(cal_done && q.size() == 0 && !pend) && n < 20000) begin
      @(posedge clk); n++;
    end
    #2;
    chk(cal_done == 1'b1, req, "calibration finished", cal_done, 1);
    chk(q.size() == 0, req, "passes left unseen", q.size(), 0);
  endtask

  task automatic check_off(input int code);
    for (int k = 0; k < 2; k++) begin
      chk(cal_pwr_off == 1'b1, "R6", "cal_pwr_off when finished", cal_pwr_off, 1);
      chk(ref_clk_en == 1'b0, "R6", "ref_clk_en when finished", ref_clk_en, 0);
      chk(integ_hold == 1'b1, "R6", "integ_hold when finished", integ_hold, 1);
      chk(cap_code == 5'(code), "R6", "final cap_code", cap_code, code);
      repeat (20) @(posedge clk);
      #2;
    end
    start = 1'b1;
    @(posedge clk); #2;
    start = 1'b0;
    repeat (HOLD + 4) @(posedge clk);
    #2;
    chk(cal_done == 1'b1, "R8", "done after late start", cal_done, 1);
    chk(integ_hold == 1'b1, "R8", "integ_hold after late start", integ_hold, 1);
    chk(cap_code == 5'(code), "R8", "cap_code after late start", cap_code, code);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog run did not finish actual=0 expected=1");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    // Pattern 1: constant delay, settles after one change.
    for (int i = 0; i < 32; i++) kv[i] = 20;
    start_run(40, 3, 1'b1);
    wait_done("R5");
    check_off(20);

    // Pattern 2: upper clip, two changes, then settles (need 2).
    kv[0] = 5; kv[1] = 30;
    for (int i = 2; i < 32; i++) kv[i] = 25;
    start_run(50, 2, 1'b0);
    wait_done("R4");
    check_off(25);

    // Pattern 3: comparator never fires, count saturates, lower clip.
    for (int i = 0; i < 32; i++) kv[i] = 70;
    start_run(10, 1, 1'b0);
    wait_done("R3");
    check_off(0);

    // Pattern 4: code equal to midscale with need 0 finishes on the first pass.
    for (int i = 0; i < 32; i++) kv[i] = 0;
    start_run(16, 0, 1'b0);
    wait_done("R5");
    check_off(16);

    // Restart while ramping in the third pass (R7).
    for (int i = 0; i < 32; i++) kv[i] = 20;
    start_run(40, 3, 1'b0);
    while (!(idx == 2 && !integ_hold)) @(posedge clk);
    #2;
    mon_en = 1'b0;
    start = 1'b1;
    @(posedge clk); #2;
    start = 1'b0;
    @(negedge clk); #1;
    chk(integ_hold == 1'b1, "R7", "integ_hold after restart", integ_hold, 1);
    chk(cap_code == 5'd16, "R7", "cap_code after restart", cap_code, 16);
    chk(cal_done == 1'b0, "R7", "done after restart", cal_done, 0);
    seen_rise = 1'b0; idx = 0; pend = 1'b0;
    build_exp(40, 3);
    mon_en = 1'b1;
    wait_done("R7");
    check_off(20);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule